// File: doc/BRIEF.md
# Bubble-Free Pipeline Stage Chain

This block is a chain of pipeline stages. Each stage holds one data item and hands it on with valid/ready flow control. The main stage type has room for one entry. It tells its producer it can take a word when it is empty. It also does so when its own entry leaves at the same clock edge. A stage that is full and draining therefore accepts a new word every cycle, so a chain of such stages moves one item per cycle with every stage occupied. A stall at the far end blocks all stages in the same cycle.

The cost of this scheme is a combinational ready path from the tail of the chain back to its head. To bound that path, a parameter can replace every k-th stage with a two-entry stage. That stage derives its ready only from its own fill level, so the ready path stops there. A clear input empties every stage at the next edge, whatever else happens in that cycle.

Each single-entry stage is a small state machine with states EMPTY and FULL and these transitions:
- ACCEPT: EMPTY to FULL on an enqueue.
- DRAIN: FULL to EMPTY on a dequeue with no enqueue.
- SWAP: FULL to FULL when dequeue and enqueue happen together. The old word leaves first, then the new word is stored.
- HOLD: no change.
- CLEAR: any state to EMPTY.

The two-entry stage has states NONE, ONE and TWO. Its transitions are FILL (NONE to ONE), STACK (ONE to TWO), PASS (ONE to ONE with a dequeue and an enqueue together), EMPTYOUT (ONE to NONE), SHIFT (TWO to ONE) and CLEAR (any state to NONE).

Top module: `pipe_chain`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Every word accepted at the input and not discarded by a clear leaves at the output exactly once, in acceptance order.
- R3: While out_valid is 1, out_ready is 0 and clr is 0, the next cycle again shows out_valid 1 with the same out_data.
- R4: A single-entry stage shows ready when it is empty or when its entry is being taken in the same cycle. In a chain of only single-entry stages that is fully occupied, out_ready 1 gives in_ready 1 in the same cycle.
- R5: With in_valid and out_ready held at 1, once the chain has filled, out_valid and in_ready are 1 in every cycle. One word moves per cycle, with no bubbles.
- R6: In a fully occupied chain of only single-entry stages, out_ready 0 drives in_ready to 0 in the same cycle.
- R7: A word accepted into an empty chain at a clock edge first shows on out_valid after STAGES-1 further edges. Both stage types add one edge each.
- R8: A clr sampled at an edge empties every stage. Any word accepted at that same edge is discarded. In the next cycle out_valid is 0 and in_ready is 1, and no stale word appears later.
- R9: A two-entry stage is ready whenever it holds fewer than two words, independent of its consumer in that cycle. In a chain whose first two-entry stage is at position BREAK_EVERY, in_ready does not change when out_ready changes within a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of every stage |
| in_valid | input | 1 | Producer offers in_data |
| in_ready | output | 1 | Chain takes in_data at the next edge if in_valid |
| in_data | input | DATA_W | Incoming word |
| out_valid | output | 1 | out_data holds a word |
| out_ready | input | 1 | Consumer takes out_data at the next edge |
| out_data | output | DATA_W | Oldest word in the chain |

## Verification
The bench builds two chains of four 16-bit stages side by side. The first uses BREAK_EVERY = 0, so every stage is a single-entry stage. This makes the same-cycle stall from tail to head, the pass-through ready and the bubble-free steady state visible at the ports. The second uses BREAK_EVERY = 2, so single-entry and two-entry stages alternate. There, toggling out_ready within one cycle shows that in_ready no longer follows it. Both chains get the same randomly timed valid, ready and clear pattern, and each output stream is compared against a queue of sequence numbers.

// File: rtl/pipe_buf_pkg.sv
package pipe_buf_pkg;

    typedef enum logic {
        SLOT_EMPTY,
        SLOT_FULL
    } slot_e;

    typedef enum logic [1:0] {
        PAIR_NONE,
        PAIR_ONE,
        PAIR_TWO
    } pair_e;

endpackage

// File: rtl/pass_slot.sv
module pass_slot
    import pipe_buf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    slot_e             state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              enq, deq;

    // pass-through ready: free now, or freed by the dequeue at this edge
    always_comb begin
        in_ready  = (state_q == SLOT_EMPTY) || out_ready;
        out_valid = (state_q == SLOT_FULL);
        out_data  = data_q;
    end

    assign enq = in_valid && in_ready;
    assign deq = out_valid && out_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (enq) state_d = SLOT_FULL;            // ACCEPT
            SLOT_FULL:  if (deq && !enq) state_d = SLOT_EMPTY;   // DRAIN; SWAP/HOLD stay
        endcase
        if (clr) state_d = SLOT_EMPTY;                           // CLEAR
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   data_q <= '0;
        else if (enq) data_q <= in_data;
    end

    a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

    a_r4_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !clr) |=> out_valid);

    a_r8_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !out_valid);

endmodule

// File: rtl/pair_buf.sv
module pair_buf
    import pipe_buf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    pair_e             state_q, state_d;
    logic [DATA_W-1:0] head_q, tail_q;
    logic              enq, deq;

    // ready from own occupancy only: the feedback path ends here
    always_comb begin
        in_ready  = (state_q != PAIR_TWO);
        out_valid = (state_q != PAIR_NONE);
        out_data  = head_q;
    end

    assign enq = in_valid && in_ready;
    assign deq = out_valid && out_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PAIR_NONE: if (enq) state_d = PAIR_ONE;                    // FILL
            PAIR_ONE: begin
                if (enq && !deq)      state_d = PAIR_TWO;              // STACK
                else if (deq && !enq) state_d = PAIR_NONE;             // EMPTYOUT
            end
            PAIR_TWO: if (deq) state_d = PAIR_ONE;                     // SHIFT
            default:  state_d = PAIR_NONE;
        endcase
        if (clr) state_d = PAIR_NONE;                                  // CLEAR
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PAIR_NONE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            unique case (state_q)
                PAIR_NONE: if (enq) head_q <= in_data;
                PAIR_ONE: begin
                    if (enq && deq) head_q <= in_data;
                    else if (enq)   tail_q <= in_data;
                end
                PAIR_TWO: if (deq) head_q <= tail_q;
                default: ;
            endcase
        end
    end

    a_r3_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

    a_r9_pair_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !out_ready && !clr) |=> !in_ready);

    a_r9_pair_full_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);

    a_r8_pair_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_ready && !out_valid));

endmodule

// File: rtl/pipe_chain.sv
module pipe_chain #(
    parameter int DATA_W      = 16,
    parameter int STAGES      = 4,
    parameter int BREAK_EVERY = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int LINKS   = STAGES + 1;
    localparam int BRK_DIV = (BREAK_EVERY > 0) ? BREAK_EVERY : 1;

    logic              lnk_valid [LINKS];
    logic              lnk_ready [LINKS];
    logic [DATA_W-1:0] lnk_data  [LINKS];

    assign lnk_valid[0]      = in_valid;
    assign lnk_data[0]       = in_data;
    assign in_ready          = lnk_ready[0];
    assign out_valid         = lnk_valid[STAGES];
    assign out_data          = lnk_data[STAGES];
    assign lnk_ready[STAGES] = out_ready;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (BREAK_EVERY > 0 && ((g + 1) % BRK_DIV) == 0) begin : g_pair
            pair_buf #(.DATA_W(DATA_W)) u_buf (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (clr),
                .in_valid (lnk_valid[g]),
                .in_ready (lnk_ready[g]),
                .in_data  (lnk_data[g]),
                .out_valid(lnk_valid[g+1]),
                .out_ready(lnk_ready[g+1]),
                .out_data (lnk_data[g+1])
            );
        end else begin : g_slot
            pass_slot #(.DATA_W(DATA_W)) u_buf (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (clr),
                .in_valid (lnk_valid[g]),
                .in_ready (lnk_ready[g]),
                .in_data  (lnk_data[g]),
                .out_valid(lnk_valid[g+1]),
                .out_ready(lnk_ready[g+1]),
                .out_data (lnk_data[g+1])
            );
        end
    end

    a_r3_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

    a_r8_chain_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_ready && !out_valid));

endmodule

// File: tb/tb_pipe_chain.sv
`timescale 1ns/1ps
module tb_pipe_chain;

    localparam int DW = 16;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic          out_ready = 1'b0;
    logic [DW-1:0] in_data_a = '0, in_data_b = '0;
    logic          rdy_a, rdy_b, ov_a, ov_b;
    logic [DW-1:0] od_a, od_b;

    int n_checks = 0;
    int n_fail   = 0;
    int seq_a = 0, seq_b = 0;
    int q_a[$];
    int q_b[$];

    always #2 clk = ~clk;

    pipe_chain #(.DATA_W(DW), .STAGES(NS), .BREAK_EVERY(0)) dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_ready(rdy_a), .in_data(in_data_a),
        .out_valid(ov_a), .out_ready(out_ready), .out_data(od_a));

    pipe_chain #(.DATA_W(DW), .STAGES(NS), .BREAK_EVERY(2)) dut_brk (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .in_valid(in_valid), .in_ready(rdy_b), .in_data(in_data_b),
        .out_valid(ov_b), .out_ready(out_ready), .out_data(od_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int seq_word(input int s);
        return s & ((1 << DW) - 1);
    endfunction

    // one cycle: drive at negedge, then update models from the handshakes
    task automatic tick(input bit iv, input bit ordy, input bit cl);
        @(negedge clk);
        in_valid  = iv;
        out_ready = ordy;
        clr       = cl;
        in_data_a = DW'(seq_a);
        in_data_b = DW'(seq_b);
        #1;
        if (ov_a && out_ready) begin
            if (q_a.size() == 0) check(1'b0, "R2 chain-a extra word", int'(od_a), -1);
            else begin
                int e = q_a.pop_front();
                check(int'(od_a) == seq_word(e), "R2 chain-a order", int'(od_a), seq_word(e));
            end
        end
        if (ov_b && out_ready) begin
            if (q_b.size() == 0) check(1'b0, "R2 chain-b extra word", int'(od_b), -1);
            else begin
                int e = q_b.pop_front();
                check(int'(od_b) == seq_word(e), "R2 chain-b order", int'(od_b), seq_word(e));
            end
        end
        if (in_valid && rdy_a) begin q_a.push_back(seq_a); seq_a++; end
        if (in_valid && rdy_b) begin q_b.push_back(seq_b); seq_b++; end
        if (clr) begin q_a.delete(); q_b.delete(); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] held_a, held_b;
        logic          ra, rb;
        void'($urandom(32'd20240611));

        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        check(ov_a == 1'b0 && ov_b == 1'b0, "R1 out_valid in reset", int'(ov_a | ov_b), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rdy_a && rdy_b, "R1 in_ready after reset", int'(rdy_a & rdy_b), 1);
        check(!ov_a && !ov_b, "R1 out_valid after reset", int'(ov_a | ov_b), 0);

        // R7 latency through empty chain
        tick(1, 1, 0);
        for (int k = 1; k <= NS; k++) begin
            tick(0, 1, 0);
            check(ov_a == (k == NS), "R7 chain-a latency", int'(ov_a), int'(k == NS));
            check(ov_b == (k == NS), "R7 chain-b latency", int'(ov_b), int'(k == NS));
        end

        // R5 full throughput, no bubbles
        for (int k = 0; k < 40; k++) begin
            tick(1, 1, 0);
            if (k >= NS + 1) begin
                check(ov_a && rdy_a, "R5 chain-a steady flow", int'({ov_a, rdy_a}), 3);
                check(ov_b && rdy_b, "R5 chain-b steady flow", int'({ov_b, rdy_b}), 3);
            end
        end

        // R6 same-cycle stall, R4 pass-through, R9 local ready
        tick(1, 0, 0);
        check(rdy_a == 1'b0, "R6 stall reaches head", int'(rdy_a), 0);
        ra = rdy_b;
        out_ready = 1'b1;
        #0.5;
        check(rdy_a == 1'b1, "R4 full chain ready on dequeue", int'(rdy_a), 1);
        rb = rdy_b;
        check(ra == rb, "R9 breaker ready ignores out_ready", int'(rb), int'(ra));
        out_ready = 1'b0;
        #0.2;

        // R3 hold while stalled
        held_a = od_a;
        held_b = od_b;
        for (int k = 0; k < 5; k++) begin
            tick(1, 0, 0);
            check(ov_a && od_a == held_a, "R3 chain-a hold", int'(od_a), int'(held_a));
            check(ov_b && od_b == held_b, "R3 chain-b hold", int'(od_b), int'(held_b));
        end

        // R8 clear, including a same-edge enqueue
        tick(0, 1, 0);
        tick(0, 1, 0);
        tick(1, 1, 1);
        tick(0, 0, 0);
        check(!ov_a && !ov_b, "R8 empty after clear", int'(ov_a | ov_b), 0);
        check(rdy_a && rdy_b, "R8 ready after clear", int'(rdy_a & rdy_b), 1);
        for (int k = 0; k < NS + 2; k++) begin
            tick(0, 1, 0);
            check(!ov_a && !ov_b, "R8 no stale word", int'(ov_a | ov_b), 0);
        end

        // random traffic against the scoreboard (R2, R3)
        for (int k = 0; k < 4000; k++) begin
            bit iv, ordy, cl;
            iv   = ($urandom % 4) != 0;
            ordy = ($urandom % 3) != 0;
            cl   = ($urandom % 250) == 0;
            tick(iv, ordy, cl);
        end

        // drain: nothing lost
        for (int k = 0; k < 4 * NS; k++) tick(0, 1, 0);
        check(q_a.size() == 0, "R2 chain-a all delivered", q_a.size(), 0);
        check(q_b.size() == 0, "R2 chain-b all delivered", q_b.size(), 0);
        check(!ov_a && !ov_b, "R2 no word left", int'(ov_a | ov_b), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule